// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number after a translation-cache miss. A request carries the address, a write flag and a privilege flag; the privilege flag picks either the supervisor or the user root table. The walker fetches the root-level (segment) entry and then the leaf (page) entry. Each fetch goes through a single read port whose latency may be any number of cycles of one or more. Only 4 KB pages are supported.

The walker checks validity at each level and write protection over both levels. When the leaf entry's reference or modify flag needs to change, it updates the entry with a read-modify-write. At the end it raises a one-cycle completion pulse. The pulse carries either the frame number and the page attributes, or one of three fault codes. Caching of translations and of data belongs to other blocks.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `busy`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: The first read goes to the root-table byte address (base << 12) + VA[31:22] * 4. The base is `sup_base` when `req_super` is 1, and `usr_base` otherwise.
- R3: The second read goes to (root entry bits 31:12) << 12 + VA[21:12] * 4.
- R4: When bit 1 of the root entry is 0, the walk ends with `fault` = 1 (missing page table). No leaf read is made. Bit 0 of the root entry has no effect.
- R5: When bit 0 of the leaf entry is 0, the walk ends with `fault` = 2 (missing page). Bit 1 of the leaf entry has no effect.
- R6: A write access ends with `fault` = 3 (protection) when root bit 2 or leaf bit 2 is 1. In that case the leaf entry is not written. A read access under the same bits succeeds with `res_ro` = 1.
- R7: A successful walk reports `fault` = 0, `res_frame` = leaf bits 31:12, `res_nocache` = leaf bit 6, and `res_ro` = root bit 2 OR leaf bit 2.
- R8: On success, the walker writes the leaf entry back at its own address in two cases: when leaf bit 3 (reference) is 0, or when the access is a write and leaf bit 4 (modify) is 0. The written value is the old entry with bit 3 set, and with bit 4 also set for a write. Otherwise no write is issued.
- R9: `done` is high for exactly one cycle. It rises (L+1) cycles per read after the request is taken, where L is the read latency, plus one cycle if a write-back occurs. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor table, 0 = user table |
| sup_base | input | 20 | Frame number of the supervisor root table |
| usr_base | input | 20 | Frame number of the user root table |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_wr_en | output | 1 | One-cycle write request |
| mem_addr | output | 32 | Byte address for read or write |
| mem_wr_data | output | 32 | Write data |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 missing table, 2 missing page, 3 protection |
| res_frame | output | 20 | Physical frame number |
| res_ro | output | 1 | Page is read-only |
| res_nocache | output | 1 | Page must not be cached |

## Verification
The walk is run with both privilege modes and with both a one-cycle and a three-cycle read latency. Root and leaf addresses, and the cycle on which completion occurs, must follow the latency; this separates a correct handshake from a hard-wired delay. Separate cases clear the root valid bit, clear the leaf valid bit, and set each read-only bit on its own; this tells apart the three fault kinds and shows that the unused valid bit at each level has no effect. Leaf entries with the reference and modify flags in each combination show when the write-back happens and what it contains. A second request raised mid-walk checks that busy requests are dropped.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_va,
  input  logic                  req_write,
  input  logic                  req_super,
  input  logic [31-OFF_W:0]     sup_base,
  input  logic [31-OFF_W:0]     usr_base,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wr_data,
  input  logic                  mem_rd_valid,
  input  logic [31:0]           mem_rd_data,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            fault,
  output logic [31-OFF_W:0]     res_frame,
  output logic                  res_ro,
  output logic                  res_nocache
);
  localparam int FRM_W = 32 - OFF_W;
  localparam int SEG_LO = OFF_W + IDX_W;

  typedef enum logic [2:0] {IDLE, READ_STE, READ_PTE, UPDATE_PTE, DONE} st_t;

  st_t              st;
  logic [31:0]      va_q, ste_q, pte_q;
  logic [FRM_W-1:0] base_q;
  logic             wr_q, pend;
  logic [1:0]       fault_q;

  logic [31:0] ste_addr, pte_addr;
  logic        ro, need_upd;

  assign ste_addr = {base_q, {OFF_W{1'b0}}} + 32'({va_q[31:SEG_LO], 2'b00});
  assign pte_addr = {ste_q[31:OFF_W], {OFF_W{1'b0}}} + 32'({va_q[SEG_LO-1:OFF_W], 2'b00});
  assign ro       = ste_q[2] | mem_rd_data[2];
  assign need_upd = !mem_rd_data[3] || (wr_q && !mem_rd_data[4]);

  assign mem_rd_en   = (st == READ_STE || st == READ_PTE) && !pend;
  assign mem_wr_en   = (st == UPDATE_PTE);
  assign mem_addr    = (st == READ_STE) ? ste_addr : pte_addr;
  assign mem_wr_data = pte_q | 32'h8 | (wr_q ? 32'h10 : 32'h0);

  assign busy        = (st != IDLE);
  assign done        = (st == DONE);
  assign fault       = fault_q;
  assign res_frame   = pte_q[31:OFF_W];
  assign res_ro      = ste_q[2] | pte_q[2];
  assign res_nocache = pte_q[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      va_q    <= '0;
      ste_q   <= '0;
      pte_q   <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      pend    <= 1'b0;
      fault_q <= 2'd0;
    end else begin
      case (st)
        IDLE: begin
          pend <= 1'b0;
          if (req_valid) begin
            va_q    <= req_va;
            wr_q    <= req_write;
            base_q  <= req_super ? sup_base : usr_base;
            fault_q <= 2'd0;
            st      <= READ_STE;
          end
        end
        READ_STE: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rd_valid) begin
            ste_q <= mem_rd_data;
            pend  <= 1'b0;
            if (!mem_rd_data[1]) begin
              fault_q <= 2'd1;
              pte_q   <= '0;
              st      <= DONE;
            end else st <= READ_PTE;
          end
        end
        READ_PTE: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rd_valid) begin
            pte_q <= mem_rd_data;
            pend  <= 1'b0;
            if (!mem_rd_data[0]) begin
              fault_q <= 2'd2;
              st      <= DONE;
            end else if (wr_q && ro) begin
              fault_q <= 2'd3;
              st      <= DONE;
            end else if (need_upd) st <= UPDATE_PTE;
            else st <= DONE;
          end
        end
        UPDATE_PTE: st <= DONE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] fault,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic [31:0] mem_wr_data
);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  a_r1_one_op: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_en && mem_wr_en));
  a_r8_ref_set: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> mem_wr_data[3]);
  a_r6_write_ok: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |=> (done && fault == 2'd0));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_rd_en || mem_wr_en));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_va = 0;
  logic [19:0] sup_base = 20'h00100, usr_base = 20'h00200;
  logic mem_rd_en, mem_wr_en, mem_rd_valid = 0;
  logic [31:0] mem_addr, mem_wr_data, mem_rd_data = 0;
  logic busy, done, res_ro, res_nocache;
  logic [1:0] fault;
  logic [19:0] res_frame;

  pt_walker u0 (.*);

  int checks = 0, failures = 0;
  int lat = 1, wcnt = 0;
  logic [31:0] raddr;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_wr_en) mem[mem_addr] = mem_wr_data;
    if (mem_rd_en) begin wcnt = lat; raddr = mem_addr; end
    if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin mem_rd_valid <= 1'b1; mem_rd_data <= rdm(raddr); end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ste_addr_of(logic [31:0] va, bit sup);
    return (sup ? 32'(sup_base) : 32'(usr_base)) * 4096 + 32'(va[31:22]) * 4;
  endfunction

  function automatic logic [31:0] pte_addr_of(logic [31:0] va, logic [31:0] ste);
    return (ste >> 12) * 4096 + 32'(va[21:12]) * 4;
  endfunction

  task automatic setup(logic [31:0] va, bit sup, logic [31:0] ste, logic [31:0] pte);
    mem[ste_addr_of(va, sup)] = ste;
    mem[pte_addr_of(va, ste)] = pte;
  endtask

  task automatic walk(logic [31:0] va, bit wr, bit sup, bit poke);
    logic [31:0] sa, pa, ste, pte, wdata, pte_after;
    int reads, nrd, edges, expc, ef;
    bit upd, ro, fin;
    sa = ste_addr_of(va, sup);
    ste = rdm(sa);
    upd = 0; ro = 0; pa = 0; pte = 0;
    if (!ste[1]) begin ef = 1; reads = 1; end
    else begin
      pa = pte_addr_of(va, ste);
      pte = rdm(pa);
      reads = 2;
      ro = ste[2] | pte[2];
      if (!pte[0]) ef = 2;
      else if (wr && ro) ef = 3;
      else begin ef = 0; upd = !pte[3] || (wr && !pte[4]); end
    end
    wdata = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
    pte_after = upd ? wdata : pte;
    expc = reads * (lat + 1) + int'(upd);

    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr; req_super = sup;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    edges = 0; nrd = 0; fin = 0;
    for (int k = 0; k < 40 && !fin; k++) begin
      if (poke && edges == 1) begin req_valid = 1; req_va = 32'hFFC0_0000; end
      else req_valid = 0;
      chk("R9 busy during walk", busy, 1);
      if (mem_rd_en) begin
        nrd++;
        if (nrd == 1) chk("R2 root address", mem_addr, sa);
        else if (nrd == 2) chk("R3 leaf address", mem_addr, pa);
        else chk("R4 no extra read", nrd, reads);
      end
      if (mem_wr_en) begin
        chk("R8 write-back expected", 1, upd);
        chk("R8 write-back address", mem_addr, pa);
        chk("R8 write-back data", mem_wr_data, wdata);
      end
      if (done) begin
        fin = 1;
        chk("R9 done cycle", edges, expc);
        chk("R4 R5 R6 fault code", 32'(fault), 32'(ef));
        chk("R4 R5 read count", nrd, reads);
        if (ef == 0) begin
          chk("R7 frame", 32'(res_frame), pte >> 12);
          chk("R7 nocache", 32'(res_nocache), 32'(pte[6]));
          chk("R7 read-only attr", 32'(res_ro), 32'(ro));
        end
      end else begin
        @(posedge clk); edges++; @(negedge clk);
      end
    end
    chk("R9 walk completed", fin, 1);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 idle after poke", busy, 0);
    if (ef != 1) chk("R6 R8 leaf entry in memory", rdm(pa), pte_after);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done low", done, 0);
    chk("R1 busy low", busy, 0);
    chk("R1 no read", mem_rd_en, 0);
    chk("R1 no write", mem_wr_en, 0);
    rst_n = 1;
    @(negedge clk);

    for (int p = 0; p < 2; p++) begin
      lat = (p == 0) ? 1 : 3;
      // R7 R8 user read, reference clear
      setup(32'h1234_5678 + p * 32'h0040_0000, 0, 32'h0030_000A, 32'h0AB1_2041);
      walk(32'h1234_5678 + p * 32'h0040_0000, 0, 0, 0);
      // R8 supervisor write, reference set, modify clear
      setup(32'h4000_3000 + p * 32'h0040_0000, 1, 32'h0031_0002, 32'h0CD0_0009);
      walk(32'h4000_3000 + p * 32'h0040_0000, 1, 1, 0);
      // R8 read with reference already set: no write-back
      setup(32'h5000_7000 + p * 32'h0040_0000, 1, 32'h0032_0002, 32'h0EE0_0049);
      walk(32'h5000_7000 + p * 32'h0040_0000, 0, 1, 0);
      // R4 root invalid (bit 0 set, bit 1 clear)
      setup(32'h6000_1000 + p * 32'h0040_0000, 0, 32'h0033_0009, 32'h0);
      walk(32'h6000_1000 + p * 32'h0040_0000, 0, 0, 0);
      // R5 leaf invalid (bit 1 set, bit 0 clear)
      setup(32'h7000_2000 + p * 32'h0040_0000, 0, 32'h0034_0002, 32'h0FF0_0002);
      walk(32'h7000_2000 + p * 32'h0040_0000, 0, 0, 0);
      // R6 write to read-only leaf
      setup(32'h8000_4000 + p * 32'h0040_0000, 0, 32'h0035_0002, 32'h0110_0005);
      walk(32'h8000_4000 + p * 32'h0040_0000, 1, 0, 0);
      // R6 write to read-only segment
      setup(32'h9000_5000 + p * 32'h0040_0000, 1, 32'h0036_0006, 32'h0120_0019);
      walk(32'h9000_5000 + p * 32'h0040_0000, 1, 1, 0);
      // R6 R7 read through read-only segment, cache inhibited, R9 poke while busy
      setup(32'hA000_6000 + p * 32'h0040_0000, 1, 32'h0037_0006, 32'h0130_0041);
      walk(32'hA000_6000 + p * 32'h0040_0000, 0, 1, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule